// File: doc/BRIEF.md
# Byte-Splittable Index Register Pair

This block is a 16-bit index register built from two bytes: X holds the high half and Y the low half. Together they form the word XY. A datapath sequencer can step either byte on its own or step the whole word, with the carry or borrow out of Y passing into X. Either byte can be written from, or shown on, an 8-bit data bus. The whole word can be written from, or shown on, a 16-bit address bus, and that bus also carries 16-bit moves between registers.

Every control is a plain level sampled on the rising clock edge. No control can be refused or stalled, so there is no back-pressure: a load or step that is asserted in a cycle takes effect at the end of that cycle. The bus outputs are modelled as an enable plus a value. The value is forced to zero while its enable is low, so the sources on a bus can be OR-combined. Both bus outputs show the contents the register holds in the current cycle.

When more than one control is raised in the same cycle, a fixed priority picks one action. Reset comes first. Then comes a word load, then a byte load, then a word step, and last a byte step.

Top module: `idxpair_reg`

## Requirements
- R1: `rst` is synchronous. A cycle with `rst` high leaves XY = 0x0000, whatever other controls are raised.
- R2: `x_inc` adds 1 to X and `x_dec` subtracts 1 from X. The result wraps within 8 bits (0xFF+1 = 0x00, 0x00-1 = 0xFF), and Y stays unchanged.
- R3: `y_inc` and `y_dec` step Y by one and wrap within 8 bits. X stays unchanged, so no carry or borrow leaves Y.
- R4: `xy_inc` adds 1 to the 16-bit word and `xy_dec` subtracts 1 from it. The carry or borrow goes from Y into X, and the word wraps: 0xFFFF+1 = 0x0000 and 0x0000-1 = 0xFFFF.
- R5: `ld_x` copies `dbus_in` into X, and `ld_y` copies `dbus_in` into Y. The other byte keeps its value.
- R6: `ld_xy` copies `abus_in` into the word: X takes bits 15:8 and Y takes bits 7:0.
- R7: When several controls are raised together, the priority from highest to lowest is `ld_xy`, `ld_x`, `ld_y`, `xy_inc`, `xy_dec`, `x_inc`, `x_dec`, `y_inc`, `y_dec`. Only the highest one acts.
- R8: `dbus_oe` = `show_x` | `show_y`. `dbus_out` is X when `show_x` is high, otherwise Y when `show_y` is high, and 0x00 when neither is high.
- R9: `abus_oe` = `show_xy`. `abus_out` is XY when `show_xy` is high, otherwise 0x0000.
- R10: A cycle with no control raised leaves XY unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous clear, highest priority |
| ld_xy | input | 1 | Load word from address bus |
| ld_x | input | 1 | Load X from data bus |
| ld_y | input | 1 | Load Y from data bus |
| xy_inc | input | 1 | Word increment |
| xy_dec | input | 1 | Word decrement |
| x_inc | input | 1 | X increment |
| x_dec | input | 1 | X decrement |
| y_inc | input | 1 | Y increment |
| y_dec | input | 1 | Y decrement |
| show_x | input | 1 | Drive X onto data bus |
| show_y | input | 1 | Drive Y onto data bus |
| show_xy | input | 1 | Drive XY onto address bus |
| dbus_in | input | 8 | Data bus value to load |
| abus_in | input | 16 | Address bus value to load |
| dbus_oe | output | 1 | Data bus output enable |
| dbus_out | output | 8 | Data bus driven value, zero when not enabled |
| abus_oe | output | 1 | Address bus output enable |
| abus_out | output | 16 | Address bus driven value, zero when not enabled |

## Verification
The bench builds the block with its default half width of 8 bits, which gives a 16-bit word. At this width a random walk of byte and word steps reaches the 0xFF and 0x00 byte edges often. Directed steps add the cases that random stimulus rarely reaches: the full-word wrap at 0xFFFF and 0x0000, a carry from 0x00FF, a borrow from 0x0100, and byte steps at 0xFF that must not carry into the other byte. Random cycles that raise several controls at once exercise the priority order, and a rare random reset checks that it overrides everything else.

// File: rtl/idxpair_pkg.sv
package idxpair_pkg;
  // per-byte action chosen by the control decoder
  typedef enum logic [1:0] {
    HOP_HOLD = 2'd0,
    HOP_LOAD = 2'd1,
    HOP_INC  = 2'd2,
    HOP_DEC  = 2'd3
  } half_op_e;
endpackage

// File: rtl/idxpair_half.sv
module idxpair_half #(
  parameter int W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  idxpair_pkg::half_op_e op,
  input  logic [W-1:0]          ld_val,
  output logic [W-1:0]          q
);
  import idxpair_pkg::*;

  logic [W-1:0] q_nxt;

  always_comb begin
    unique case (op)
      HOP_LOAD: q_nxt = ld_val;
      HOP_INC:  q_nxt = q + W'(1);
      HOP_DEC:  q_nxt = q - W'(1);
      default:  q_nxt = q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= q_nxt;
  end

  // R1
  rst_clear_chk: assert property (@(posedge clk) rst |=> q == '0);

  // R10
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    op == HOP_HOLD |=> $stable(q));
endmodule

// File: rtl/idxpair_ctrl.sv
module idxpair_ctrl #(
  parameter int W = 8
) (
  input  logic                  ld_xy,
  input  logic                  ld_x,
  input  logic                  ld_y,
  input  logic                  xy_inc,
  input  logic                  xy_dec,
  input  logic                  x_inc,
  input  logic                  x_dec,
  input  logic                  y_inc,
  input  logic                  y_dec,
  input  logic [W-1:0]          y_q,
  output idxpair_pkg::half_op_e op_x,
  output idxpair_pkg::half_op_e op_y
);
  import idxpair_pkg::*;

  logic y_full, y_empty;
  assign y_full  = &y_q;
  assign y_empty = ~|y_q;

  // priority chain: word load, byte load, word step, byte step (R7)
  always_comb begin
    op_x = HOP_HOLD;
    op_y = HOP_HOLD;
    if (ld_xy) begin
      op_x = HOP_LOAD;
      op_y = HOP_LOAD;
    end else if (ld_x) begin
      op_x = HOP_LOAD;
    end else if (ld_y) begin
      op_y = HOP_LOAD;
    end else if (xy_inc) begin
      op_y = HOP_INC;
      op_x = y_full ? HOP_INC : HOP_HOLD;
    end else if (xy_dec) begin
      op_y = HOP_DEC;
      op_x = y_empty ? HOP_DEC : HOP_HOLD;
    end else if (x_inc) begin
      op_x = HOP_INC;
    end else if (x_dec) begin
      op_x = HOP_DEC;
    end else if (y_inc) begin
      op_y = HOP_INC;
    end else if (y_dec) begin
      op_y = HOP_DEC;
    end
  end
endmodule

// File: rtl/idxpair_drive.sv
module idxpair_drive #(
  parameter int W = 8
) (
  input  logic [2*W-1:0] word,
  input  logic           show_x,
  input  logic           show_y,
  input  logic           show_xy,
  output logic           dbus_oe,
  output logic [W-1:0]   dbus_out,
  output logic           abus_oe,
  output logic [2*W-1:0] abus_out
);
  assign dbus_oe = show_x | show_y;
  assign abus_oe = show_xy;

  always_comb begin
    if (show_x)      dbus_out = word[2*W-1:W];
    else if (show_y) dbus_out = word[W-1:0];
    else             dbus_out = '0;
    abus_out = show_xy ? word : '0;
  end
endmodule

// File: rtl/idxpair_reg.sv
module idxpair_reg #(
  parameter int HALF_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ld_xy,
  input  logic                ld_x,
  input  logic                ld_y,
  input  logic                xy_inc,
  input  logic                xy_dec,
  input  logic                x_inc,
  input  logic                x_dec,
  input  logic                y_inc,
  input  logic                y_dec,
  input  logic                show_x,
  input  logic                show_y,
  input  logic                show_xy,
  input  logic [HALF_W-1:0]   dbus_in,
  input  logic [2*HALF_W-1:0] abus_in,
  output logic                dbus_oe,
  output logic [HALF_W-1:0]   dbus_out,
  output logic                abus_oe,
  output logic [2*HALF_W-1:0] abus_out
);
  import idxpair_pkg::*;

  localparam int WORD_W = 2 * HALF_W;
  localparam int NHALF  = 2;  // index 0 = Y (low), 1 = X (high)

  half_op_e          op_x, op_y;
  half_op_e          half_op [NHALF];
  logic [HALF_W-1:0] ld_val  [NHALF];
  logic [HALF_W-1:0] half_q  [NHALF];
  logic [WORD_W-1:0] xy;

  idxpair_ctrl #(.W(HALF_W)) u_ctrl (
    .ld_xy(ld_xy), .ld_x(ld_x), .ld_y(ld_y),
    .xy_inc(xy_inc), .xy_dec(xy_dec),
    .x_inc(x_inc), .x_dec(x_dec), .y_inc(y_inc), .y_dec(y_dec),
    .y_q(half_q[0]), .op_x(op_x), .op_y(op_y)
  );

  assign half_op[0] = op_y;
  assign half_op[1] = op_x;

  for (genvar i = 0; i < NHALF; i++) begin : g_half
    assign ld_val[i] = ld_xy ? abus_in[i*HALF_W +: HALF_W] : dbus_in;
    idxpair_half #(.W(HALF_W)) u_half (
      .clk(clk), .rst(rst), .op(half_op[i]), .ld_val(ld_val[i]), .q(half_q[i])
    );
  end

  assign xy = {half_q[1], half_q[0]};

  idxpair_drive #(.W(HALF_W)) u_drive (
    .word(xy), .show_x(show_x), .show_y(show_y), .show_xy(show_xy),
    .dbus_oe(dbus_oe), .dbus_out(dbus_out),
    .abus_oe(abus_oe), .abus_out(abus_out)
  );

  // R4
  word_inc_carry_chk: assert property (@(posedge clk) disable iff (rst)
    (xy_inc && !ld_xy && !ld_x && !ld_y) |=> xy == $past(xy) + WORD_W'(1));

  // R4
  word_dec_borrow_chk: assert property (@(posedge clk) disable iff (rst)
    (xy_dec && !xy_inc && !ld_xy && !ld_x && !ld_y) |=> xy == $past(xy) - WORD_W'(1));

  // R6
  word_load_chk: assert property (@(posedge clk) disable iff (rst)
    ld_xy |=> xy == $past(abus_in));

  // R2
  x_step_keeps_y_chk: assert property (@(posedge clk) disable iff (rst)
    ((x_inc || x_dec) && !ld_xy && !ld_x && !ld_y && !xy_inc && !xy_dec)
    |=> half_q[0] == $past(half_q[0]));

  // R3
  y_step_keeps_x_chk: assert property (@(posedge clk) disable iff (rst)
    ((y_inc || y_dec) && !ld_xy && !ld_x && !ld_y && !xy_inc && !xy_dec && !x_inc && !x_dec)
    |=> half_q[1] == $past(half_q[1]));

  // R9
  abus_idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !abus_oe |-> abus_out == '0);

  // R8
  dbus_idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !dbus_oe |-> dbus_out == '0);
endmodule

// File: tb/idxpair_reg_bench.sv
`timescale 1ns/1ps
module idxpair_reg_bench;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  // control bundle bit order: 9 rst, 8 ld_xy, 7 ld_x, 6 ld_y, 5 xy_inc,
  // 4 xy_dec, 3 x_inc, 2 x_dec, 1 y_inc, 0 y_dec
  logic [9:0]  c;
  logic        show_x, show_y, show_xy;
  logic [7:0]  dbus_in;
  logic [15:0] abus_in;
  logic        dbus_oe, abus_oe;
  logic [7:0]  dbus_out;
  logic [15:0] abus_out;

  idxpair_reg u_idxpair_reg (
    .clk(clk), .rst(c[9]), .ld_xy(c[8]), .ld_x(c[7]), .ld_y(c[6]),
    .xy_inc(c[5]), .xy_dec(c[4]), .x_inc(c[3]), .x_dec(c[2]),
    .y_inc(c[1]), .y_dec(c[0]),
    .show_x(show_x), .show_y(show_y), .show_xy(show_xy),
    .dbus_in(dbus_in), .abus_in(abus_in),
    .dbus_oe(dbus_oe), .dbus_out(dbus_out),
    .abus_oe(abus_oe), .abus_out(abus_out)
  );

  int checks = 0;
  int errors = 0;
  logic [15:0] m = 16'h0000;
  string tag = "R1";

  function automatic logic [15:0] model(logic [15:0] s, logic [9:0] k,
                                        logic [7:0] d, logic [15:0] a);
    if (k[9])      return 16'h0000;
    else if (k[8]) return a;
    else if (k[7]) return {d, s[7:0]};
    else if (k[6]) return {s[15:8], d};
    else if (k[5]) return s + 16'd1;
    else if (k[4]) return s - 16'd1;
    else if (k[3]) return {s[15:8] + 8'd1, s[7:0]};
    else if (k[2]) return {s[15:8] - 8'd1, s[7:0]};
    else if (k[1]) return {s[15:8], s[7:0] + 8'd1};
    else if (k[0]) return {s[15:8], s[7:0] - 8'd1};
    return s;
  endfunction

  function automatic string tag_of(logic [9:0] k);
    if (k[9])                  return "R1";
    if ($countones(k) > 1)     return "R7";
    if (k[8])                  return "R6";
    if (k[7] || k[6])          return "R5";
    if (k[5] || k[4])          return "R4";
    if (k[3] || k[2])          return "R2";
    if (k[1] || k[0])          return "R3";
    return "R10";
  endfunction

  task automatic chk(input bit ok, input string t, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", t, what, act, exp);
    end
  endtask

  // one cycle: drive at negedge, check outputs, then model the edge
  task automatic step(input logic [9:0] k, input logic sx, input logic sy,
                      input logic sa, input logic [7:0] d, input logic [15:0] a);
    logic [7:0] dexp;
    @(negedge clk);
    c = k; show_x = sx; show_y = sy; show_xy = sa; dbus_in = d; abus_in = a;
    #1;
    dexp = sx ? m[15:8] : (sy ? m[7:0] : 8'h00);
    chk(dbus_oe == (sx | sy), "R8", "dbus_oe", {15'd0, dbus_oe}, {15'd0, sx | sy});
    chk(dbus_out == dexp, (sx | sy) ? tag : "R8", "dbus_out", {8'd0, dbus_out}, {8'd0, dexp});
    chk(abus_oe == sa, "R9", "abus_oe", {15'd0, abus_oe}, {15'd0, sa});
    chk(abus_out == (sa ? m : 16'h0000), sa ? tag : "R9", "abus_out",
        abus_out, sa ? m : 16'h0000);
    @(posedge clk);
    m = model(m, k, d, a);
    tag = tag_of(k);
  endtask

  task automatic set_word(input logic [15:0] v);
    step(10'b01_0000_0000, 1'b0, 1'b0, 1'b0, 8'h00, v);
  endtask

  task automatic peek();
    step(10'b0, 1'b0, 1'b0, 1'b1, 8'h00, 16'h0000);
  endtask

  initial begin
    c = 10'b10_0000_0000; show_x = 0; show_y = 0; show_xy = 0;
    dbus_in = 8'h00; abus_in = 16'h0000;
    void'($urandom(32'd20240517));
    repeat (3) @(posedge clk);
    m = 16'h0000; tag = "R1";
    // R1 reset state
    peek();
    // R4 carry from 0x00FF and wrap at 0xFFFF
    set_word(16'h00FF); step(10'b00_0010_0000, 0, 0, 1, 8'h00, 16'h0); peek();
    set_word(16'hFFFF); step(10'b00_0010_0000, 0, 0, 1, 8'h00, 16'h0); peek();
    // R4 borrow from 0x0100 and wrap at 0x0000
    set_word(16'h0100); step(10'b00_0001_0000, 0, 0, 1, 8'h00, 16'h0); peek();
    set_word(16'h0000); step(10'b00_0001_0000, 0, 0, 1, 8'h00, 16'h0); peek();
    // R3 Y wraps at 0xFF without touching X
    set_word(16'h12FF); step(10'b00_0000_0010, 0, 0, 1, 8'h00, 16'h0); peek();
    set_word(16'h3400); step(10'b00_0000_0001, 0, 0, 1, 8'h00, 16'h0); peek();
    // R2 X wraps without touching Y
    set_word(16'hFF56); step(10'b00_0000_1000, 0, 0, 1, 8'h00, 16'h0); peek();
    set_word(16'h0078); step(10'b00_0000_0100, 0, 0, 1, 8'h00, 16'h0); peek();
    // R5 byte loads, read back on the data bus
    step(10'b00_1000_0000, 0, 0, 0, 8'hA5, 16'h0);
    step(10'b00_0100_0000, 1, 0, 0, 8'h3C, 16'h0);
    step(10'b0, 0, 1, 0, 8'h00, 16'h0);
    step(10'b0, 1, 1, 1, 8'h00, 16'h0);
    // R7 word load beats everything but reset
    step(10'b01_1111_1111, 0, 0, 1, 8'h11, 16'hBEEF); peek();
    // R1 reset beats word load
    step(10'b11_0000_0000, 0, 0, 1, 8'h00, 16'h1234); peek();
    // random walk
    for (int i = 0; i < 4000; i++) begin
      logic [9:0] k;
      int r;
      k = 10'b0;
      r = $urandom % 12;
      if (r < 9) k[r] = 1'b1;
      if ($urandom % 100 < 15) k[$urandom % 9] = 1'b1;
      if ($urandom % 100 < 2) k[9] = 1'b1;
      step(k, ($urandom % 3) == 0, ($urandom % 2) == 0, ($urandom % 4) != 0,
           8'($urandom), 16'($urandom));
    end
    peek();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule